// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Front End

This block is the processor-facing side of an eight-line interrupt controller. A byte-wide port with a single address bit carries two kinds of traffic. A short chain of configuration bytes sets up the controller: the vector base, whether a final options byte follows, and the options in that byte. Single-byte commands then select what reads return, arm a poll, set the special mask flag, and retire or rotate in-service interrupts. The block holds the request, in-service and mask registers and the rotating priority offset. It resolves the highest-priority pending line and presents it as an interrupt request and, on acknowledge, as a vector.

Software first writes an initialization byte to address 0 and then two or three bytes to address 1. After that, address-1 writes load the mask, and address-0 writes are commands. External logic pulses `irq_set` to latch requests and pulses `ack` to take the current winner into service.

Top module: `irq_ctl_frontend`

## Requirements
- R1: Reset, or an address-0 write with bit 4 set, clears the request, in-service and mask registers, the priority offset, the vector base, read select, poll, special mask, auto-EOI, rotate-on-auto-EOI and nesting flags. Such a write also records its bit 0 as "options byte expected" and makes the next address-1 write the vector base.
- R2: The vector-base write stores the data ANDed with 0xF8. An acknowledge presents base OR winning line on `ack_vec`, or base OR 7 when no line wins.
- R3: After the base write, the next address-1 write is discarded. Control then passes to the options step if bit 0 of the initialization write was 1, and to normal operation otherwise. Only in normal operation do address-1 writes load the mask.
- R4: In the options step, data bit 4 sets the nesting flag (seen on `nest_mode`) and data bit 1 sets auto-EOI.
- R5: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is 1, loads read select from bit 0 only when bit 1 is 1, and loads the special mask (seen on `spec_mask`) from bit 5 only when bit 6 is 1.
- R6: Any other address-0 write is a command whose code is bits 7:5. Code 1 clears the highest-priority in-service bit and changes nothing when the in-service register is empty.
- R7: Code 5 clears the same bit as code 1 and sets the priority offset to that line plus 1, modulo 8.
- R8: Code 3 clears the in-service bit named by data bits 2:0. Code 7 does the same and sets the offset to that line plus 1, modulo 8.
- R9: Code 6 sets the offset to data bits 2:0 plus 1, modulo 8. Codes 0 and 4 load rotate-on-auto-EOI with code bit 2. Code 2 has no effect.
- R10: A read without poll returns, at address 0, the in-service register when read select is 1 and the request register when it is 0. At address 1 it returns the mask.
- R11: A read while poll is armed returns the winning line and clears its request and in-service bits, or returns 7 when no line wins. Poll is then cleared.
- R12: `int_req` is high when the highest-priority unmasked request outranks every in-service line. `ack` while it is high sets that line in service and clears its request.
- R13: With auto-EOI set, an acknowledge leaves the in-service register unchanged. When rotate-on-auto-EOI is also set, the acknowledge sets the offset to the line plus 1.
- R14: Priority is circular. The line equal to the offset ranks highest, and rank falls with each line number above it, wrapping past 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (needed for poll side effects) |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| irq_set | input | 8 | Per-line request pulses |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| ack_vec | output | 8 | Vector for the current acknowledge |
| nest_mode | output | 1 | Nesting flag from the options byte |
| spec_mask | output | 1 | Special mask flag |

## Verification
The bench targets the conditional options step. A sequencer that always or never waits for it would load the mask one write early or late, and the read-back would show that. An empty non-specific EOI must leave nothing changed, and an offset update on the wrong line would reorder later arbitration between two pending lines chosen so that the orders differ. The mode command gates read select and special mask with enable bits, so an ungated load would flip the register read back. Poll must fall after a single read, so a sticky poll would return 7 in place of the plain register value. Auto-EOI with and without rotation is checked by a following acknowledge whose winner depends on whether the offset moved.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int DW    = 8;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_OPTS = 2'd3
  } init_step_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF   = 3'd0,
    OP_EOI       = 3'd1,
    OP_IDLE      = 3'd2,
    OP_EOI_LINE  = 3'd3,
    OP_ROT_ON    = 3'd4,
    OP_EOI_ROT   = 3'd5,
    OP_SET_PRIO  = 3'd6,
    OP_LINE_ROT  = 3'd7
  } op_code_e;

  // line that holds a given rank for a given rotation offset
  function automatic logic [IDX_W-1:0] line_at(input logic [IDX_W-1:0] rank,
                                               input logic [IDX_W-1:0] off);
    return rank + off;
  endfunction

  // offset that makes the line after 'line' the highest priority
  function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] line);
    return line + 1'b1;
  endfunction
endpackage

// File: rtl/irqc_rank.sv
module irqc_rank
  import irqc_pkg::*;
(
  input  logic [LINES-1:0] vec,
  input  logic [IDX_W-1:0] off,
  output logic             found,
  output logic [IDX_W-1:0] rank,
  output logic [IDX_W-1:0] line
);
  logic [LINES-1:0] rot;

  for (genvar r = 0; r < LINES; r++) begin : g_rot
    localparam logic [IDX_W-1:0] RK = IDX_W'(r);
    assign rot[r] = vec[line_at(RK, off)];
  end

  always_comb begin
    rank = '0;
    for (int r = LINES - 1; r >= 0; r--) begin
      if (rot[r]) rank = IDX_W'(r);
    end
  end

  assign found = |vec;
  assign line  = line_at(rank, off);
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    base,
  output logic             aeoi,
  output logic             rot_aeoi,
  output logic             nest,
  output logic             smm,
  output logic             rsel,
  output logic             poll,
  output logic             init_evt,
  output logic             mask_wr,
  output logic             eoi_ns,
  output logic             eoi_ns_rot,
  output logic             eoi_sp,
  output logic             eoi_sp_rot,
  output logic             prio_set,
  output logic [IDX_W-1:0] cmd_line
);
  localparam logic [DW-1:0] BASE_MASK = ~DW'(LINES - 1);

  init_step_e step;
  logic       need_opts;
  logic       wr_cmd, wr_cfg, mode_evt, op_evt, rot_wr;
  op_code_e   code;

  assign wr_cmd   = wr_en && !addr;
  assign wr_cfg   = wr_en && addr;
  assign init_evt = wr_cmd && wdata[4];
  assign mode_evt = wr_cmd && !wdata[4] && wdata[3];
  assign op_evt   = wr_cmd && !wdata[4] && !wdata[3];
  assign code     = op_code_e'(wdata[7:5]);
  assign cmd_line = wdata[IDX_W-1:0];

  assign eoi_ns     = op_evt && (code == OP_EOI || code == OP_EOI_ROT);
  assign eoi_ns_rot = op_evt && (code == OP_EOI_ROT);
  assign eoi_sp     = op_evt && (code == OP_EOI_LINE || code == OP_LINE_ROT);
  assign eoi_sp_rot = op_evt && (code == OP_LINE_ROT);
  assign prio_set   = op_evt && (code == OP_SET_PRIO);
  assign rot_wr     = op_evt && (code == OP_ROT_OFF || code == OP_ROT_ON);
  assign mask_wr    = wr_cfg && (step == STEP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= STEP_RUN; need_opts <= 1'b0; base <= '0;
      aeoi <= 1'b0; rot_aeoi <= 1'b0; nest <= 1'b0;
      smm <= 1'b0; rsel <= 1'b0; poll <= 1'b0;
    end else if (init_evt) begin
      step <= STEP_BASE; need_opts <= wdata[0]; base <= '0;
      aeoi <= 1'b0; rot_aeoi <= 1'b0; nest <= 1'b0;
      smm <= 1'b0; rsel <= 1'b0; poll <= 1'b0;
    end else begin
      if (wr_cfg) begin
        case (step)
          STEP_BASE: begin
            base <= wdata & BASE_MASK;
            step <= STEP_SKIP;
          end
          STEP_SKIP: step <= need_opts ? STEP_OPTS : STEP_RUN;
          STEP_OPTS: begin
            nest <= wdata[4];
            aeoi <= wdata[1];
            step <= STEP_RUN;
          end
          default: ;
        endcase
      end
      if (rd_en && poll) poll <= 1'b0;
      if (mode_evt) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
        if (wdata[6]) smm  <= wdata[5];
      end
      if (rot_wr) rot_aeoi <= wdata[7];
    end
  end

  a_r1_init_restart: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (step == STEP_BASE && !poll && !rsel && !smm && !aeoi));
  a_r3_base_then_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_BASE && wr_en && addr) |=> (step == STEP_SKIP));
  a_r3_opts_then_run: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_OPTS && wr_en && addr) |=> (step == STEP_RUN));
  a_r11_poll_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll && !wr_en) |=> !poll);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_evt,
  input  logic             mask_wr,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] irq_set,
  input  logic             ack_evt,
  input  logic             poll_evt,
  input  logic [IDX_W-1:0] win_line,
  input  logic             aeoi,
  input  logic             rot_aeoi,
  input  logic             eoi_ns,
  input  logic             eoi_ns_rot,
  input  logic             top_found,
  input  logic [IDX_W-1:0] top_line,
  input  logic             eoi_sp,
  input  logic             eoi_sp_rot,
  input  logic             prio_set,
  input  logic [IDX_W-1:0] cmd_line,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] imr,
  output logic [IDX_W-1:0] off
);
  logic [LINES-1:0] irr_n, isr_n, imr_n;
  logic [IDX_W-1:0] off_n;

  always_comb begin
    irr_n = irr | irq_set;
    isr_n = isr;
    imr_n = mask_wr ? wdata[LINES-1:0] : imr;
    off_n = off;
    if (eoi_ns && top_found) begin
      isr_n[top_line] = 1'b0;
      if (eoi_ns_rot) off_n = after(top_line);
    end
    if (eoi_sp) begin
      isr_n[cmd_line] = 1'b0;
      if (eoi_sp_rot) off_n = after(cmd_line);
    end
    if (prio_set) off_n = after(cmd_line);
    if (ack_evt) begin
      irr_n[win_line] = 1'b0;
      if (!aeoi) isr_n[win_line] = 1'b1;
      else if (rot_aeoi) off_n = after(win_line);
    end
    if (poll_evt) begin
      irr_n[win_line] = 1'b0;
      isr_n[win_line] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; off <= '0;
    end else if (init_evt) begin
      irr <= '0; isr <= '0; imr <= '0; off <= '0;
    end else begin
      irr <= irr_n; isr <= isr_n; imr <= imr_n; off <= off_n;
    end
  end

  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (irr == '0 && isr == '0 && imr == '0 && off == '0));
  a_r6_empty_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && isr == '0 && !ack_evt && !poll_evt) |=> (isr == '0));
  a_r11_poll_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_evt && !ack_evt && !init_evt) |=> !isr[$past(win_line)]);
  a_r12_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !aeoi && !poll_evt && !init_evt) |=> isr[$past(win_line)]);
  a_r13_auto_eoi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && aeoi && !eoi_ns && !eoi_sp && !poll_evt && !init_evt) |=> $stable(isr));
endmodule

// File: rtl/irq_ctl_frontend.sv
module irq_ctl_frontend
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [LINES-1:0] irq_set,
  input  logic             ack,
  output logic             int_req,
  output logic [DW-1:0]    ack_vec,
  output logic             nest_mode,
  output logic             spec_mask
);
  localparam logic [IDX_W-1:0] SPURIOUS = IDX_W'(LINES - 1);

  logic [DW-1:0]    base;
  logic             aeoi, rot_aeoi, rsel, poll;
  logic             init_evt, mask_wr, eoi_ns, eoi_ns_rot, eoi_sp, eoi_sp_rot, prio_set;
  logic [IDX_W-1:0] cmd_line;
  logic [LINES-1:0] irr, isr, imr, pend;
  logic [IDX_W-1:0] off;
  logic             req_found, isr_found, win_valid, ack_evt, poll_evt;
  logic [IDX_W-1:0] req_rank, req_line, isr_rank, isr_line, win_line;

  irqc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .base(base), .aeoi(aeoi), .rot_aeoi(rot_aeoi), .nest(nest_mode), .smm(spec_mask),
    .rsel(rsel), .poll(poll), .init_evt(init_evt), .mask_wr(mask_wr),
    .eoi_ns(eoi_ns), .eoi_ns_rot(eoi_ns_rot), .eoi_sp(eoi_sp), .eoi_sp_rot(eoi_sp_rot),
    .prio_set(prio_set), .cmd_line(cmd_line)
  );

  assign pend = irr & ~imr;

  irqc_rank u_req_rank (
    .vec(pend), .off(off), .found(req_found), .rank(req_rank), .line(req_line)
  );

  irqc_rank u_isr_rank (
    .vec(isr), .off(off), .found(isr_found), .rank(isr_rank), .line(isr_line)
  );

  assign win_valid = req_found && (!isr_found || (req_rank < isr_rank));
  assign win_line  = req_line;
  assign ack_evt   = ack && win_valid;
  assign poll_evt  = rd_en && poll && win_valid;
  assign int_req   = win_valid;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .init_evt(init_evt), .mask_wr(mask_wr), .wdata(wdata),
    .irq_set(irq_set), .ack_evt(ack_evt), .poll_evt(poll_evt), .win_line(win_line),
    .aeoi(aeoi), .rot_aeoi(rot_aeoi), .eoi_ns(eoi_ns), .eoi_ns_rot(eoi_ns_rot),
    .top_found(isr_found), .top_line(isr_line), .eoi_sp(eoi_sp), .eoi_sp_rot(eoi_sp_rot),
    .prio_set(prio_set), .cmd_line(cmd_line),
    .irr(irr), .isr(isr), .imr(imr), .off(off)
  );

  always_comb begin
    if (poll)      rdata = DW'(win_valid ? win_line : SPURIOUS);
    else if (addr) rdata = DW'(imr);
    else           rdata = rsel ? DW'(isr) : DW'(irr);
  end

  assign ack_vec = base | DW'(win_valid ? win_line : SPURIOUS);

  a_r12_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr[win_line] && !imr[win_line]));
  a_r14_winner_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && isr_found) |-> !isr[win_line]);
endmodule

// File: tb/irq_ctl_frontend_test.sv
module irq_ctl_frontend_test;
  localparam logic [3:0] OP_WR = 4'h0, OP_RD = 4'h1, OP_IRQ = 4'h2,
                         OP_ACK = 4'h3, OP_INT = 4'h4, OP_FLG = 4'h5;
  localparam int NV = 50;
  // entry: op | requirement | addr byte | data | expected
  localparam logic [31:0] VEC [NV] = '{
    32'h01001100, // R1 init, options byte expected
    32'h02014B00, // R2 base 0x4B & 0xF8 = 0x48
    32'h0301FF00, // R3 discarded step
    32'h04010000, // R4 options: nothing set
    32'h03010F00, // R3 now a mask write
    32'h1A01000F, // R10 mask read
    32'h2C001200, // R12 requests on lines 1,4
    32'h1A000012, // R10 request register read
    32'h4C000001, // R12 line 4 wins, line 1 masked
    32'h3C00004C, // R12 vector 0x48|4
    32'h05000B00, // R5 read select = in-service
    32'h1A000010, // R10 in-service read
    32'h4C000000, // R12 only masked request left
    32'h03010000, // R3 unmask
    32'h4C000001, // R12 line 1 outranks in-service line 4
    32'h3C000049, // R12 vector 0x49
    32'h06002000, // R6 non-specific EOI retires line 1
    32'h16000010, // R6
    32'h2C002000, // R12 line 5 request
    32'h4C000000, // R12 blocked by line 4 in service
    32'h06002000, // R6 retires line 4
    32'h16000000, // R6
    32'h4C000001, // R12 line 5 now asserts
    32'h06002000, // R6 EOI with empty in-service
    32'h16000000, // R6 still empty
    32'h05000A00, // R5 read select = request
    32'h1A000020, // R10
    32'h05000B00, // R5 read select = in-service
    32'h05000800, // R5 bit 1 clear: select kept
    32'h15000000, // R5 still in-service view
    32'h0B000C00, // R11 arm poll
    32'h1B000005, // R11 poll returns line 5
    32'h1B000000, // R11 poll dropped, plain read
    32'h0B000C00, // R11 arm poll
    32'h1B010007, // R11 nothing pending -> 7
    32'h2E008100, // R14 lines 0,7
    32'h0900C300, // R9 offset = 4
    32'h3E00004F, // R14 line 7 ranks above line 0
    32'h4E000000, // R14 line 0 below in-service line 7
    32'h0700A000, // R7 rotating EOI: offset = 0
    32'h27004000, // R7 add line 6
    32'h37000048, // R7 line 0 first with offset 0
    32'h08006000, // R8 specific EOI line 0
    32'h18000000, // R8
    32'h3C00004E, // R12 line 6
    32'h0800E600, // R8 clear line 6, offset = 7
    32'h28008100, // R8 lines 0,7
    32'h3800004F, // R8 line 7 highest
    32'h09004700, // R9 code 2 does nothing
    32'h19000080  // R9 in-service unchanged
  };

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, addr, ack, int_req, nest_mode, spec_mask;
  logic [7:0] wdata, rdata, irq_set, ack_vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_ctl_frontend uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_set(irq_set), .ack(ack), .int_req(int_req),
    .ack_vec(ack_vec), .nest_mode(nest_mode), .spec_mask(spec_mask)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] rq,
                                     input logic a, input logic [7:0] d, input logic [7:0] e);
    return {op, rq, 7'd0, a, d, e};
  endfunction

  task automatic step(input logic [31:0] v);
    @(negedge clk);
    case (v[31:28])
      OP_WR:  begin wr_en = 1'b1; addr = v[16]; wdata = v[15:8]; end
      OP_RD:  begin rd_en = 1'b1; addr = v[16]; end
      OP_IRQ: irq_set = v[15:8];
      OP_ACK: ack = 1'b1;
      default: ;
    endcase
    #1;
    case (v[31:28])
      OP_RD:  check(int'(v[27:24]), rdata, v[7:0], "read data");
      OP_ACK: check(int'(v[27:24]), ack_vec, v[7:0], "ack vector");
      OP_INT: check(int'(v[27:24]), {7'd0, int_req}, v[7:0], "int_req");
      OP_FLG: check(int'(v[27:24]), {6'd0, nest_mode, spec_mask}, v[7:0], "flags");
      default: ;
    endcase
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0; irq_set = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; ack = 1'b0;
    wdata = '0; irq_set = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state, R1
    step(mk(OP_RD, 4'd1, 1'b0, 8'h00, 8'h00));
    step(mk(OP_RD, 4'd1, 1'b1, 8'h00, 8'h00));
    step(mk(OP_INT, 4'd1, 1'b0, 8'h00, 8'h00));
    step(mk(OP_ACK, 4'd1, 1'b0, 8'h00, 8'h07));
    step(mk(OP_FLG, 4'd1, 1'b0, 8'h00, 8'h00));

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // special mask gating, R5
    step(mk(OP_WR, 4'd5, 1'b0, 8'h68, 8'h00));
    step(mk(OP_FLG, 4'd5, 1'b0, 8'h00, 8'h01));
    step(mk(OP_WR, 4'd5, 1'b0, 8'h28, 8'h00));
    step(mk(OP_FLG, 4'd5, 1'b0, 8'h00, 8'h01));
    step(mk(OP_WR, 4'd5, 1'b0, 8'h48, 8'h00));
    step(mk(OP_FLG, 4'd5, 1'b0, 8'h00, 8'h00));

    // init without options byte: R1, R3, spurious vector R2
    step(mk(OP_WR, 4'd1, 1'b0, 8'h10, 8'h00));
    step(mk(OP_RD, 4'd1, 1'b0, 8'h00, 8'h00));
    step(mk(OP_INT, 4'd1, 1'b0, 8'h00, 8'h00));
    step(mk(OP_WR, 4'd2, 1'b1, 8'h0F, 8'h00));
    step(mk(OP_WR, 4'd3, 1'b1, 8'h33, 8'h00));
    step(mk(OP_RD, 4'd3, 1'b1, 8'h00, 8'h00));
    step(mk(OP_WR, 4'd3, 1'b1, 8'hAA, 8'h00));
    step(mk(OP_RD, 4'd3, 1'b1, 8'h00, 8'hAA));
    step(mk(OP_ACK, 4'd2, 1'b0, 8'h00, 8'h0F));

    // auto-EOI with and without rotation: R4, R13, R9
    step(mk(OP_WR, 4'd1, 1'b0, 8'h11, 8'h00));
    step(mk(OP_WR, 4'd2, 1'b1, 8'h30, 8'h00));
    step(mk(OP_WR, 4'd3, 1'b1, 8'h00, 8'h00));
    step(mk(OP_WR, 4'd4, 1'b1, 8'h12, 8'h00));
    step(mk(OP_FLG, 4'd4, 1'b0, 8'h00, 8'h02));
    step(mk(OP_WR, 4'd9, 1'b0, 8'h80, 8'h00));
    step(mk(OP_IRQ, 4'd13, 1'b0, 8'h04, 8'h00));
    step(mk(OP_ACK, 4'd13, 1'b0, 8'h00, 8'h32));
    step(mk(OP_WR, 4'd5, 1'b0, 8'h0B, 8'h00));
    step(mk(OP_RD, 4'd13, 1'b0, 8'h00, 8'h00));
    step(mk(OP_IRQ, 4'd13, 1'b0, 8'h0C, 8'h00));
    step(mk(OP_ACK, 4'd13, 1'b0, 8'h00, 8'h33)); // R13 offset moved to 3
    step(mk(OP_WR, 4'd9, 1'b0, 8'h00, 8'h00));
    step(mk(OP_IRQ, 4'd9, 1'b0, 8'h11, 8'h00));
    step(mk(OP_ACK, 4'd9, 1'b0, 8'h00, 8'h34));
    step(mk(OP_IRQ, 4'd9, 1'b0, 8'h50, 8'h00));
    step(mk(OP_ACK, 4'd9, 1'b0, 8'h00, 8'h34)); // R9 offset held at 4

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule